// File: doc/BRIEF.md
# Card Slot Status and Board Identity Registers

This block is a small register window on a platform's control bus. Three of its words are fixed: a board identity value, a reserved word that reads zero, and a decode description constant. The fourth word is the status word for a removable memory card slot. Software polls it or takes an interrupt from it.

The status word holds two different kinds of bit. One bit shows the current level of the slot's write-protect switch and changes whenever that level changes. The other bit records that a card-insert event happened. Once it is set it stays set, even after the insert signal drops, until software clears it by writing a one to its position. While that sticky bit is set, the block drives its interrupt output. The bus is word addressed and 32 bits wide. Read data is registered and appears one cycle after the read strobe.

Top module: `slot_ctl_regs`

## Requirements
- R1: After synchronous reset, `bus_rdata` is zero, `card_irq` is low, and a read of word 2 returns zero.
- R2: A read that is sampled on a clock edge puts its data on `bus_rdata` after that edge, where it stays until the next read. Word 0 returns 0x41034003, word 1 returns 0 and word 3 returns 0x00000011.
- R3: A write to word 0, 1 or 3, or to any word from 4 upward, changes neither the read value of any word nor `card_irq`.
- R4: Bit 0 of word 2 is the level of `wp_lvl` as sampled on the previous clock edge.
- R5: Bit 3 of word 2 becomes 1 on any clock edge where `card_ins` is high. It stays 1 after `card_ins` returns low.
- R6: A write to word 2 with data bit 3 equal to 1 clears bit 3 of word 2. The other data bits of that write have no effect, and bit 0 cannot be written.
- R7: If `card_ins` is high on the same edge as a clearing write, the set wins and bit 3 stays 1.
- R8: `card_irq` always equals bit 3 of word 2.
- R9: Bits 31..4 and bits 2..1 of word 2 read as zero. Words 4 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Word index of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| wp_lvl | input | 1 | Write-protect switch level from the slot |
| card_ins | input | 1 | Card-insert indication from the slot |
| card_irq | output | 1 | Interrupt request, high while the insert flag is set |

## Verification
The bench builds the block with its defaults: a 4-bit word index (16 words) and 32-bit data, with the write-protect bit at position 0 and the insert flag at position 3. Because the window is so small, the bench can read every word index and can write every index with a set of data patterns (all ones, all zeros, alternating bits, single bits at positions 0 and 3), always from a state where both status bits are 1. That makes every decode hole, every ignored data bit and the single clearing bit visible at the ports. Set against clear on the same edge is driven directly.

// File: rtl/slot_ctl_pkg.sv
package slot_ctl_pkg;

  // Word indices on the register window; the status index is decoded by
  // software drivers, so its placement is behavioural.
  localparam int unsigned IDX_IDENT  = 0;
  localparam int unsigned IDX_RSVD   = 1;
  localparam int unsigned IDX_STATUS = 2;
  localparam int unsigned IDX_DECODE = 3;

  typedef struct packed {
    logic card;   // sticky insert flag
    logic wp;     // live write-protect level
  } slot_stat_t;

  typedef struct packed {
    logic ident;
    logic rsvd;
    logic status;
    logic decode;
  } slot_sel_t;

endpackage

// File: rtl/slot_ctl_decode.sv
module slot_ctl_decode
  import slot_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_sel_t         sel
);

  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(IDX_IDENT);
  localparam logic [ADDR_W-1:0] A_RSVD   = ADDR_W'(IDX_RSVD);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(IDX_STATUS);
  localparam logic [ADDR_W-1:0] A_DECODE = ADDR_W'(IDX_DECODE);

  always_comb begin
    sel.ident  = (addr == A_IDENT);
    sel.rsvd   = (addr == A_RSVD);
    sel.status = (addr == A_STATUS);
    sel.decode = (addr == A_DECODE);
  end

endmodule

// File: rtl/slot_ctl_status.sv
module slot_ctl_status
  import slot_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wp_lvl,
  input  logic       card_ins,
  input  logic       clr_req,   // write to status word with clear bit set
  output slot_stat_t stat
);

  logic wp_q;
  logic card_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= 1'b0;
      card_q <= 1'b0;
    end else begin
      wp_q <= wp_lvl;
      // set has priority over clear
      if (card_ins)     card_q <= 1'b1;
      else if (clr_req) card_q <= 1'b0;
    end
  end

  assign stat.wp   = wp_q;
  assign stat.card = card_q;

  // R4
  wp_track_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (wp_q == $past(wp_lvl)));

  // R5
  card_set_chk: assert property (@(posedge clk) disable iff (rst)
    card_ins |=> card_q);

  // R5
  card_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (card_q && !clr_req) |=> card_q);

  // R6
  card_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !card_ins) |=> !card_q);

  // R7
  card_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && card_ins) |=> card_q);

  // R5
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!card_q && !card_ins) |=> !card_q);

endmodule

// File: rtl/slot_ctl_rdmux.sv
module slot_ctl_rdmux
  import slot_ctl_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter logic [DATA_W-1:0] ID_WORD     = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DECODE_WORD = 32'h0000_0011,
  parameter int unsigned WP_POS      = 0,
  parameter int unsigned CARD_POS    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  slot_sel_t         sel,
  input  slot_stat_t        stat,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] stat_word;

  // Place the two status bits; every other bit position is tied low.
  for (genvar i = 0; i < DATA_W; i++) begin : g_stat_bit
    if (i == WP_POS) begin : g_wp
      assign stat_word[i] = stat.wp;
    end else if (i == CARD_POS) begin : g_card
      assign stat_word[i] = stat.card;
    end else begin : g_zero
      assign stat_word[i] = 1'b0;
    end
  end

  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if (sel.ident)  rd_nxt = ID_WORD;
    if (sel.status) rd_nxt = stat_word;
    if (sel.decode) rd_nxt = DECODE_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_nxt;
  end

  // R2
  ident_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && sel.ident) |=> (rdata == ID_WORD));

  // R2
  decode_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && sel.decode) |=> (rdata == DECODE_WORD));

  // R9
  hole_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !sel.ident && !sel.status && !sel.decode) |=> (rdata == '0));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));

endmodule

// File: rtl/slot_ctl_regs.sv
module slot_ctl_regs
  import slot_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter logic [DATA_W-1:0] ID_WORD     = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DECODE_WORD = 32'h0000_0011,
  parameter int unsigned WP_POS      = 0,
  parameter int unsigned CARD_POS    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wp_lvl,
  input  logic              card_ins,
  output logic              card_irq
);

  slot_sel_t  sel;
  slot_stat_t stat;
  logic       clr_req;
  logic       unused_wdata;

  slot_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign clr_req      = bus_wr && sel.status && bus_wdata[CARD_POS];
  assign unused_wdata = ^bus_wdata;

  slot_ctl_status u_status (
    .clk      (clk),
    .rst      (rst),
    .wp_lvl   (wp_lvl),
    .card_ins (card_ins),
    .clr_req  (clr_req),
    .stat     (stat)
  );

  slot_ctl_rdmux #(
    .DATA_W      (DATA_W),
    .ID_WORD     (ID_WORD),
    .DECODE_WORD (DECODE_WORD),
    .WP_POS      (WP_POS),
    .CARD_POS    (CARD_POS)
  ) u_rdmux (
    .clk   (clk),
    .rst   (rst),
    .rd    (bus_rd),
    .sel   (sel),
    .stat  (stat),
    .rdata (bus_rdata)
  );

  assign card_irq = stat.card;

  // R3
  foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !sel.status && !card_ins && card_irq) |=> card_irq);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel.status) |=> (bus_rdata[CARD_POS] == card_irq));

endmodule

// File: tb/slot_ctl_regs_tb_top.sv
module slot_ctl_regs_tb_top;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] ID_V  = 32'h4103_4003;
  localparam logic [31:0] DEC_V = 32'h0000_0011;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              wp_lvl = 1'b0;
  logic              card_ins = 1'b0;
  logic              card_irq;

  int checks = 0;
  int fails  = 0;
  bit m_wp   = 1'b0;
  bit m_card = 1'b0;

  always #5 clk = ~clk;

  slot_ctl_regs dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wp_lvl    (wp_lvl),
    .card_ins  (card_ins),
    .card_irq  (card_irq)
  );

  function automatic logic [31:0] exp_word(int a);
    if (a == 0) return ID_V;
    if (a == 3) return DEC_V;
    if (a == 2) return {28'd0, m_card, 2'b00, m_wp};
    return 32'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd_word(int a, string req);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    check(req, bus_rdata, exp_word(a));
  endtask

  task automatic wr_word(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr  = ADDR_W'(a);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    if (a == 2 && d[3]) m_card = 1'b0;
  endtask

  task automatic pulse_card();
    @(negedge clk);
    card_ins = 1'b1;
    @(negedge clk);
    card_ins = 1'b0;
    m_card   = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0;        pats[2] = 32'hA5A5_A5A5;
    pats[3] = 32'h0000_0008; pats[4] = 32'h0000_0001;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 32'd0);
    check("R1 irq", {31'd0, card_irq}, 32'd0);
    rd_word(2, "R1 status");

    // R2 R9 read sweep of every word index
    for (int a = 0; a < 16; a++) rd_word(a, (a < 4) ? "R2 read" : "R9 hole");

    // R4 live write-protect level
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wp_lvl = k[0];
      m_wp   = k[0];
      rd_word(2, "R4 wp level");
    end

    // R5 R8 sticky set and interrupt
    pulse_card();
    check("R8 irq set", {31'd0, card_irq}, 32'd1);
    repeat (3) @(negedge clk);
    rd_word(2, "R5 sticky");
    check("R8 irq hold", {31'd0, card_irq}, 32'd1);

    // R3 R6 write sweep across all indices and patterns from a full state
    @(negedge clk);
    wp_lvl = 1'b1;
    m_wp   = 1'b1;
    for (int a = 0; a < 16; a++) begin
      for (int p = 0; p < 5; p++) begin
        pulse_card();
        wr_word(a, pats[p]);
        check((a == 2) ? "R6 irq after write" : "R3 irq after write",
              {31'd0, card_irq}, {31'd0, m_card});
        for (int r = 0; r < 4; r++)
          rd_word(r, (a == 2) ? "R6 read after write" : "R3 read after write");
      end
    end

    // R7 set wins over clear
    @(negedge clk);
    card_ins = 1'b1;
    wr_word(2, 32'h8);
    m_card = 1'b1;
    check("R7 irq", {31'd0, card_irq}, 32'd1);
    @(negedge clk);
    card_ins = 1'b0;
    rd_word(2, "R7 status");
    wr_word(2, 32'h8);
    check("R6 clear irq", {31'd0, card_irq}, 32'd0);
    rd_word(2, "R6 clear status");

    // R1 reset clears sticky state
    pulse_card();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    wp_lvl = 1'b0;
    m_wp = 1'b0;
    m_card = 1'b0;
    check("R1 irq after reset", {31'd0, card_irq}, 32'd0);
    rd_word(2, "R1 status after reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule